// File: doc/BRIEF.md
# Stereo Serial Audio Controller

This block moves 16-bit stereo audio between a processor and an external codec over a three-wire serial audio link. Software writes one stereo sample per word, left channel in the upper half and right channel in the lower half. Each word goes into a small transmit queue. The block shifts the sample out on the serial data line. In parallel it assembles the incoming serial data into words and parks them in a receive queue, where software reads them back in the same packing.

The block always generates the bit clock and the word clock itself, from a programmable divider. Each queue raises an alert against a software-chosen water level, and the alerts can be routed to one interrupt line. Queue overflows, transmit starvation and reads of an empty receive queue leave sticky error flags. Software clears them by writing ones to the offset where they are read. A control bit drives the codec reset pin directly.

Top module: `audio_serial_ctl`

## Requirements
- R1: After reset the control word reads 0, the error word reads 0, the divider reads 0x080 and the status word reads 0x15: transmit alert, transmit empty and receive empty are set.
- R2: Control at offset 0x00 keeps only these bits: 0 transmit enable, 1 transmit interrupt enable, 2 receive enable, 3 receive interrupt enable, 10:8 transmit level, 14:12 receive level, 16 queue flush, 17 codec reset. All other bits read 0. The `codec_rst` pin follows bit 17.
- R3: `bclk` toggles every divider+1 clock cycles, where the divider is the 10-bit value at offset 0x0C. `wclk` changes only on a falling `bclk`. It is low for 16 bit periods (left channel) and then high for 16 (right channel).
- R4: `sdout` changes only on a falling `bclk`. Each 32-bit word is sent MSB first, left half first. Its first bit starts one bit period after the falling word-clock edge.
- R5: `sdin` is sampled on rising `bclk` with the same alignment as R4. The assembled word reads at offset 0x14 with left in bits 31:16, and the read pops it.
- R6: Each queue holds 4 words. Status at offset 0x04 reports bit 2 transmit empty, bit 3 transmit full, bit 4 receive empty and bit 5 receive full.
- R7: Status bit 0 (transmit alert) is set while the number of free transmit entries exceeds the transmit level.
- R8: Status bit 1 (receive alert) is set while the number of free receive entries is below the receive level.
- R9: `irq` = (transmit alert and control bit 1) or (receive alert and control bit 3).
- R10: A write to offset 0x10 while the transmit queue is full is dropped and sets error bit 0. If transmit is enabled and a frame starts with the queue empty, zeros are sent for that frame and error bit 0 is set. With transmit disabled, zeros are sent and no error is flagged.
- R11: A word that arrives while the receive queue is full is dropped and sets error bit 1. A read of offset 0x14 while the queue is empty returns 0 and sets error bit 1. With receive disabled, nothing is stored.
- R12: The error word at offset 0x08 is sticky. Writing 1 to a bit clears it, writing 0 leaves it, and a new error in the same cycle wins over the clear.
- R13: While control bit 16 is set, both queues are emptied.
- R14: While transmit is disabled, the transmit queue is not consumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops receive data at 0x14) |
| reg_addr | input | 5 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the addressed register |
| irq | output | 1 | Combined queue interrupt |
| codec_rst | output | 1 | Codec reset pin |
| bclk | output | 1 | Serial bit clock |
| wclk | output | 1 | Word (left/right) clock |
| sdout | output | 1 | Serial data out |
| sdin | input | 1 | Serial data in |

## Verification
The bench builds the block with its default depth of 4, so queue-full, overflow and every defined water level are reached with a few words. It programs divider values of 1 and 3 at run time. That shortens a frame to 128 or 256 cycles, which allows many frames, starvation, receive overflow and flushes within a short run. It also exercises the divider reset value of 0x80 before it is reprogrammed. The serial output is looped back into the input, so every transmitted word must return unchanged through the receive queue.

// File: rtl/audio_serial_ctl.sv
module audio_serial_ctl #(
  parameter int DEPTH = 4,
  parameter int DIV_W = 10,
  parameter logic [DIV_W-1:0] DIV_RST = DIV_W'(128)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [4:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        irq,
  output logic        codec_rst,
  output logic        bclk,
  output logic        wclk,
  output logic        sdout,
  input  logic        sdin
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [31:0] CTRL_MASK = 32'h0003_770F;

  logic [31:0] ctrl_q;
  logic tx_err, rx_err;
  logic [DIV_W-1:0] div_q, div_cnt;
  logic [31:0] tx_mem [DEPTH];
  logic [31:0] rx_mem [DEPTH];
  logic [PW-1:0] tx_wp, tx_rp, rx_wp, rx_rp;
  logic [CW-1:0] tx_cnt, rx_cnt, tx_free, rx_free;
  logic [4:0] slot;
  logic [31:0] tsh, rsh;

  wire tick = div_cnt >= div_q;
  wire fall = tick & bclk;
  wire rise = tick & ~bclk;
  wire [4:0] slot_nx = slot + 5'd1;
  wire frame_load = fall && slot == 5'd31;
  wire tx_full = tx_cnt == CW'(DEPTH);
  wire rx_full = rx_cnt == CW'(DEPTH);
  wire tx_empty = tx_cnt == '0;
  wire rx_empty = rx_cnt == '0;

  wire wr_ctrl = reg_wr && reg_addr == 5'h00;
  wire wr_err  = reg_wr && reg_addr == 5'h08;
  wire wr_div  = reg_wr && reg_addr == 5'h0C;
  wire wr_buf  = reg_wr && reg_addr == 5'h10;
  wire rd_buf  = reg_rd && reg_addr == 5'h14;

  wire tx_pop   = frame_load && ctrl_q[0] && !tx_empty;
  wire tx_under = frame_load && ctrl_q[0] && tx_empty;
  wire tx_push  = wr_buf && !tx_full;
  wire tx_over  = wr_buf && tx_full;

  wire [31:0] rx_word = {rsh[30:0], sdin};
  wire rx_arrive = rise && slot == 5'd0 && ctrl_q[2];
  wire rx_push  = rx_arrive && !rx_full;
  wire rx_over  = rx_arrive && rx_full;
  wire rx_pop   = rd_buf && !rx_empty;
  wire rx_under = rd_buf && rx_empty;

  assign tx_free = CW'(DEPTH) - tx_cnt;
  assign rx_free = CW'(DEPTH) - rx_cnt;
  wire tx_alert = 32'(tx_free) > 32'(ctrl_q[10:8]);
  wire rx_alert = 32'(rx_free) < 32'(ctrl_q[14:12]);

  assign irq = (tx_alert & ctrl_q[1]) | (rx_alert & ctrl_q[3]);
  assign codec_rst = ctrl_q[17];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      div_q  <= DIV_RST;
      tx_err <= 1'b0;
      rx_err <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_q <= reg_wdata & CTRL_MASK;
      if (wr_div)  div_q  <= reg_wdata[DIV_W-1:0];
      tx_err <= (tx_err & ~(wr_err & reg_wdata[0])) | tx_under | tx_over;
      rx_err <= (rx_err & ~(wr_err & reg_wdata[1])) | rx_under | rx_over;
    end
  end

  always_ff @(posedge clk) begin
    if (tx_push) tx_mem[tx_wp] <= reg_wdata;
    if (rx_push) rx_mem[rx_wp] <= rx_word;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || ctrl_q[16]) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else begin
      if (tx_push) tx_wp <= tx_wp + PW'(1);
      if (tx_pop)  tx_rp <= tx_rp + PW'(1);
      tx_cnt <= tx_cnt + CW'(tx_push) - CW'(tx_pop);
      if (rx_push) rx_wp <= rx_wp + PW'(1);
      if (rx_pop)  rx_rp <= rx_rp + PW'(1);
      rx_cnt <= rx_cnt + CW'(rx_push) - CW'(rx_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_cnt <= '0;
      bclk    <= 1'b0;
      wclk    <= 1'b1;
      slot    <= 5'd31;
      sdout   <= 1'b0;
      tsh     <= '0;
      rsh     <= '0;
    end else begin
      div_cnt <= tick ? '0 : div_cnt + DIV_W'(1);
      if (tick) bclk <= ~bclk;
      if (fall) begin
        slot  <= slot_nx;
        wclk  <= slot_nx[4];
        sdout <= tsh[31];
        if (frame_load) tsh <= tx_pop ? tx_mem[tx_rp] : '0;
        else            tsh <= {tsh[30:0], 1'b0};
      end
      if (rise) rsh <= rx_word;
    end
  end

  always_comb begin
    case (reg_addr)
      5'h00:   reg_rdata = ctrl_q;
      5'h04:   reg_rdata = {26'd0, rx_full, rx_empty, tx_full, tx_empty, rx_alert, tx_alert};
      5'h08:   reg_rdata = {30'd0, rx_err, tx_err};
      5'h0C:   reg_rdata = 32'(div_q);
      5'h14:   reg_rdata = rx_empty ? '0 : rx_mem[rx_rp];
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/audio_serial_ctl_checks.sv
module audio_serial_ctl_checks #(
  parameter int DEPTH = 4,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bclk,
  input logic          wclk,
  input logic          sdout,
  input logic          irq,
  input logic          codec_rst,
  input logic          reg_wr,
  input logic [4:0]    reg_addr,
  input logic [31:0]   reg_wdata,
  input logic          tx_err,
  input logic [CW-1:0] tx_cnt,
  input logic [CW-1:0] rx_cnt,
  input logic [31:0]   ctrl_q
);
  assert_wclk_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(wclk) |-> $fell(bclk));

  assert_sdout_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdout) |-> $fell(bclk));

  assert_codec_pin_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 5'h00) |=> (codec_rst == $past(reg_wdata[17])));

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(tx_cnt) <= DEPTH) && (32'(rx_cnt) <= DEPTH));

  assert_err_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_err && !(reg_wr && reg_addr == 5'h08 && reg_wdata[0])) |=> tx_err);

  assert_flush_empties_R13: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[16] |=> (tx_cnt == '0 && rx_cnt == '0));

  assert_irq_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q[1] && !ctrl_q[3]) |-> !irq);
endmodule

bind audio_serial_ctl audio_serial_ctl_checks #(.DEPTH(DEPTH)) u_checks (
  .clk(clk), .rst_n(rst_n), .bclk(bclk), .wclk(wclk), .sdout(sdout),
  .irq(irq), .codec_rst(codec_rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .tx_err(tx_err), .tx_cnt(tx_cnt), .rx_cnt(rx_cnt),
  .ctrl_q(ctrl_q)
);

// File: tb/audio_serial_ctl_bench.sv
module audio_serial_ctl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  wire  [31:0] reg_rdata;
  wire irq, codec_rst, bclk, wclk, sdout;

  audio_serial_ctl u_audio_serial_ctl (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq(irq), .codec_rst(codec_rst), .bclk(bclk), .wclk(wclk),
    .sdout(sdout), .sdin(sdout)
  );

  int n_vec = 0, n_bad = 0;
  string phase = "R1";

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s [%s]: got %h expected %h", tag, phase, act, exp);
    end
  endtask

  // behavioural model
  logic [31:0] m_ctrl, m_tsh, m_rsh, ld, word;
  logic m_terr, m_rerr, m_bclk, m_wclk, m_sdout;
  int m_div, m_cnt, m_slot, tsz, rsz;
  bit tick, fall, rise, flush;
  logic [31:0] txq[$];
  logic [31:0] rxq[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctrl = 0; m_terr = 0; m_rerr = 0; m_div = 128; m_cnt = 0;
      m_bclk = 0; m_wclk = 1; m_slot = 31; m_sdout = 0; m_tsh = 0; m_rsh = 0;
      txq.delete(); rxq.delete();
    end else begin
      tick = m_cnt >= m_div; fall = tick && m_bclk; rise = tick && !m_bclk;
      tsz = txq.size(); rsz = rxq.size(); flush = m_ctrl[16];
      if (reg_wr && reg_addr == 5'h08) begin
        if (reg_wdata[0]) m_terr = 0;
        if (reg_wdata[1]) m_rerr = 0;
      end
      ld = 0;
      if (fall && m_slot == 31 && m_ctrl[0]) begin
        if (tsz > 0) ld = txq.pop_front(); else m_terr = 1;
      end
      if (reg_wr && reg_addr == 5'h10) begin
        if (tsz < 4) txq.push_back(reg_wdata); else m_terr = 1;
      end
      word = {m_rsh[30:0], m_sdout};
      if (reg_rd && reg_addr == 5'h14) begin
        if (rsz > 0) void'(rxq.pop_front()); else m_rerr = 1;
      end
      if (rise && m_slot == 0 && m_ctrl[2]) begin
        if (rsz < 4) rxq.push_back(word); else m_rerr = 1;
      end
      if (tick) begin
        m_cnt = 0;
        if (m_bclk) begin
          m_slot = (m_slot + 1) % 32;
          m_wclk = m_slot >= 16;
          m_sdout = m_tsh[31];
          m_tsh = (m_slot == 0) ? ld : (m_tsh << 1);
        end else m_rsh = word;
        m_bclk = !m_bclk;
      end else m_cnt++;
      if (reg_wr && reg_addr == 5'h00) m_ctrl = reg_wdata & 32'h0003_770F;
      if (reg_wr && reg_addr == 5'h0C) m_div = int'(reg_wdata[9:0]);
      if (flush) begin txq.delete(); rxq.delete(); end
    end
  end

  function automatic logic m_txa();
    return (4 - txq.size()) > int'(m_ctrl[10:8]);
  endfunction
  function automatic logic m_rxa();
    return (4 - rxq.size()) < int'(m_ctrl[14:12]);
  endfunction
  function automatic logic [31:0] m_rdata(logic [4:0] a);
    case (a)
      5'h00: return m_ctrl;
      5'h04: return {26'd0, rxq.size() == 4, rxq.size() == 0, txq.size() == 4,
                     txq.size() == 0, m_rxa(), m_txa()};
      5'h08: return {30'd0, m_rerr, m_terr};
      5'h0C: return 32'(m_div);
      5'h14: return (rxq.size() > 0) ? rxq[0] : 32'd0;
      default: return 32'd0;
    endcase
  endfunction
  function automatic string addr_tag(logic [4:0] a);
    case (a)
      5'h04: return "R6 R7 R8 status";
      5'h08: return "R10 R11 R12 errors";
      5'h0C: return "R1 R3 divider";
      5'h14: return "R5 receive data";
      default: return "R2 control";
    endcase
  endfunction

  always @(negedge clk) if (rst_n) begin
    chk("R3 bclk", bclk, m_bclk);
    chk("R3 wclk", wclk, m_wclk);
    chk("R4 sdout", sdout, m_sdout);
    chk("R9 irq", irq, (m_txa() & m_ctrl[1]) | (m_rxa() & m_ctrl[3]));
    chk("R2 codec_rst", codec_rst, m_ctrl[17]);
    chk(addr_tag(reg_addr), reg_rdata, m_rdata(reg_addr));
  end

  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(posedge clk); #1 reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1 reg_wr = 0;
  endtask
  task automatic rd(logic [4:0] a, output logic [31:0] v);
    @(posedge clk); #1 reg_rd = 1; reg_addr = a;
    @(negedge clk); v = reg_rdata;
    @(posedge clk); #1 reg_rd = 0;
  endtask
  task automatic idle(int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_vec++; n_bad++;
    $display("FAIL watchdog [%s]: got timeout expected completion", phase);
    finish_run();
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    idle(4);
    rd(5'h04, v); chk("R1 status after reset", v, 32'h15);
    rd(5'h0C, v); chk("R1 divider after reset", v, 32'h80);
    rd(5'h00, v); chk("R1 control after reset", v, 32'h0);
    rd(5'h08, v); chk("R1 errors after reset", v, 32'h0);

    phase = "R2";
    wr(5'h00, 32'hFFFF_FFFF);
    rd(5'h00, v); chk("R2 control mask", v, 32'h0003_770F);
    chk("R2 codec pin high", codec_rst, 1'b1);
    wr(5'h00, 32'h0000_3300);
    chk("R2 codec pin low", codec_rst, 1'b0);

    phase = "R3";
    wr(5'h0C, 32'd1);
    idle(300);

    phase = "R7";
    wr(5'h00, 32'h0000_3202);
    for (int i = 0; i < 3; i++) begin wr(5'h10, 32'hA5C3_1E70 + 32'(i) * 32'h0101_1111); idle(3); end
    phase = "R10";
    for (int i = 0; i < 2; i++) wr(5'h10, 32'h5A3C_E18F ^ 32'(i));
    rd(5'h04, v); chk("R6 transmit full flag", v[3], 1'b1);
    rd(5'h08, v); chk("R10 transmit overflow flag", v[0], 1'b1);

    phase = "R4 R5 R11";
    wr(5'h00, 32'h0000_210F);
    idle(700);
    for (int i = 0; i < 5; i++) begin rd(5'h14, v); idle(2); end

    phase = "R12";
    wr(5'h00, 32'h0);
    idle(10);
    wr(5'h08, 32'h1); idle(2);
    wr(5'h08, 32'h0); idle(2);
    wr(5'h08, 32'h3);
    rd(5'h08, v); chk("R12 errors cleared", v, 32'h0);

    phase = "R14";
    wr(5'h00, 32'h0000_0004);
    for (int i = 0; i < 4; i++) wr(5'h10, 32'h1357_9BDF + 32'(i));
    idle(300);
    rd(5'h04, v); chk("R14 transmit queue untouched", v[3], 1'b1);

    phase = "R13";
    wr(5'h00, 32'h0001_0000);
    idle(2);
    wr(5'h00, 32'h0);
    rd(5'h04, v);
    chk("R13 transmit empty after flush", v[2], 1'b1);
    chk("R13 receive empty after flush", v[4], 1'b1);

    phase = "R8";
    wr(5'h00, 32'h0000_4004);
    wr(5'h10, 32'hDEAD_BEEF);
    idle(300);
    wr(5'h00, 32'h0000_100D);
    wr(5'h10, 32'h0F1E_2D3C);
    idle(400);
    for (int i = 0; i < 4; i++) begin rd(5'h14, v); idle(3); end

    phase = "R3 R4 R5";
    wr(5'h0C, 32'd3);
    wr(5'h00, 32'h0000_0105);
    wr(5'h10, 32'h8001_7FFE);
    wr(5'h10, 32'h4C4C_B3B3);
    idle(1200);
    for (int i = 0; i < 4; i++) begin rd(5'h14, v); idle(2); end
    idle(20);
    finish_run();
  end
endmodule